// File: doc/BRIEF.md
# Sector Range Erase Sequencer for Status-Register NOR Flash

This block erases a run of consecutive sectors on a 16-bit parallel NOR flash whose progress is reported through a status register. A start pulse launches the operation with a first-sector offset and either an exclusive end offset or a single-sector flag. Sector bases and limits come from a small built-in geometry lookup: a region of small boot sectors at the bottom, then large uniform sectors up to the device size. All offsets are word addresses.

For each sector the sequencer reads the lock word in identifier mode. If the sector is locked it sends the two-write unlock. It then issues the two erase writes and polls the bank until the ready bit rises. Next it decodes the status word into an error code and returns the bank to read-array mode. A failed sector also gets a clear-status write and ends the operation. Every access uses a request/acknowledge pair toward the memory bus, one access per acknowledge. The caller sees a busy level, a one-cycle done pulse and a two-bit error code.

Top module: `nor_erase_seq`

## Requirements
- R1: A start offset that is not the base of its sector ends the operation with error code 2'b01 (alignment), and no bus access is made.
- R2: When the single flag is low, an end offset above the device size, or an end offset below the device size that is not a sector base, ends with error 2'b01 and no bus access is made.
- R3: With the single flag high, exactly the sector that starts at the start offset is erased and the end input is ignored. An end equal to the start erases nothing, ends with code 2'b00 and makes no bus access.
- R4: Each sector begins with a write of 0x0090 (identify) to its bank address, then a read at sector base + 2. A nonzero word there means locked, and a locked sector then receives 0x0060 and 0x00D0 at its base.
- R5: The erase is 0x0020 written to the bank, then 0x00D0 written to the sector base. Reads of the bank follow until status bit 7 is 1. The bank address is the sector address with its low 11 bits cleared.
- R6: The final status word is decoded with this precedence: bit 3, or bits 5 and 4 together, or bit 5 alone give 2'b10 (erase failure). Otherwise bit 1 gives 2'b11 (protection failure). Otherwise the code is 2'b00, whatever bit 4 is.
- R7: After every sector 0x00FF (read array) is written to the bank. After a failed sector 0x0050 (clear status) follows, and the operation ends with that error without touching further sectors.
- R8: A successful sector is followed by the sector starting at its limit. The operation stops when that limit equals the end offset or equals the device size (4096 words by default), so an end below the start runs to the top of the device.
- R9: Once the bus request is raised, it stays high with address, direction and write data unchanged until acknowledge is seen.
- R10: Busy is high from the cycle after an accepted start through the done pulse. Done lasts one cycle. The error output changes only with done and otherwise holds the last result. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| start_addr_i | input | AW | First sector word offset |
| end_addr_i | input | AW+1 | Exclusive end word offset (may equal device size) |
| single_i | input | 1 | Erase one sector only, end ignored |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result: 00 none, 01 alignment, 10 erase, 11 protection |
| bus_req_o | output | 1 | Memory access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Word address of the access |
| bus_wdata_o | output | 16 | Command word for writes |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access complete |

## Verification
On every cycle, the assertions check the handshake contract: the request is held with a frozen address and command until acknowledge. They also check that no request is raised while idle, that done lasts one cycle inside busy, and that the error output moves only with done. The command sequence itself can only be shown by the bench scenarios. This covers the unlock insertion for locked sectors, the order of identify, erase, polling, read-array and clear writes, and the walk across mixed sector sizes with its stop at the end offset or the device top. The scenarios also cover the status-bit precedence and the alignment rejections. There, the bench compares the full write log against a list it builds from the geometry.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_ALIGN = 2'b01,
    ERR_ERASE = 2'b10,
    ERR_PROT  = 2'b11
  } erase_err_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHK_START,
    ST_CHK_END,
    ST_ID_W,
    ST_LOCK_R,
    ST_UNL1_W,
    ST_UNL2_W,
    ST_ERA1_W,
    ST_ERA2_W,
    ST_POLL_R,
    ST_RDARR_W,
    ST_CLR_W,
    ST_FIN
  } seq_state_e;

  // status bits the decoder looks at
  typedef struct packed {
    logic rdy;
    logic b5;
    logic b4;
    logic b3;
    logic b1;
  } stat_bits_t;

endpackage

// File: rtl/nor_rst_sync.sv
module nor_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/nor_sector_limits.sv
module nor_sector_limits #(
  parameter int AW         = 12,
  parameter int SMALL_BITS = 8,
  parameter int BIG_BITS   = 10,
  parameter int BOOT_SECTS = 4
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW:0]   base_o,
  output logic [AW:0]   lim_o
);

  localparam logic [AW:0] ONE       = {{AW{1'b0}}, 1'b1};
  localparam logic [AW:0] SMALL_SZ  = ONE << SMALL_BITS;
  localparam logic [AW:0] BIG_SZ    = ONE << BIG_BITS;
  localparam logic [AW:0] SMALL_MSK = SMALL_SZ - ONE;
  localparam logic [AW:0] BIG_MSK   = BIG_SZ - ONE;
  localparam logic [AW:0] BOOT_END  = SMALL_SZ * BOOT_SECTS;

  logic [AW:0] a_ext;
  logic [AW:0] rel;

  assign a_ext = {1'b0, addr_i};

  generate
    if (BOOT_SECTS > 0) begin : g_boot
      always_comb begin
        rel = a_ext - BOOT_END;
        if (a_ext < BOOT_END) begin
          base_o = a_ext & ~SMALL_MSK;
          lim_o  = base_o + SMALL_SZ;
        end else begin
          base_o = BOOT_END + (rel & ~BIG_MSK);
          lim_o  = base_o + BIG_SZ;
        end
      end
    end else begin : g_uniform
      always_comb begin
        rel    = a_ext;
        base_o = rel & ~BIG_MSK;
        lim_o  = base_o + BIG_SZ;
      end
    end
  endgenerate

endmodule

// File: rtl/nor_status_decode.sv
module nor_status_decode
  import nor_erase_pkg::*;
(
  input  stat_bits_t st_i,
  output logic       ready_o,
  output erase_err_e code_o
);

  always_comb begin
    ready_o = st_i.rdy;
    if (st_i.b3) begin
      code_o = ERR_ERASE;          // supply fault
    end else if (st_i.b5 && st_i.b4) begin
      code_o = ERR_ERASE;          // bad command order
    end else if (st_i.b5) begin
      code_o = ERR_ERASE;          // erase did not complete
    end else if (st_i.b1) begin
      code_o = ERR_PROT;
    end else begin
      code_o = ERR_NONE;
    end
  end

endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl
  import nor_erase_pkg::*;
#(
  parameter int          AW            = 12,
  parameter int          BANK_BITS     = 11,
  parameter int          LOCK_OFS      = 2,
  parameter logic [15:0] CMD_IDENT     = 16'h0090,
  parameter logic [15:0] CMD_PROT_SET  = 16'h0060,
  parameter logic [15:0] CMD_UNLOCK    = 16'h00D0,
  parameter logic [15:0] CMD_ERA_SETUP = 16'h0020,
  parameter logic [15:0] CMD_ERA_CONF  = 16'h00D0,
  parameter logic [15:0] CMD_RD_ARRAY  = 16'h00FF,
  parameter logic [15:0] CMD_CLR_STAT  = 16'h0050
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW:0]   end_addr_i,
  input  logic          single_i,
  // geometry lookup
  output logic [AW-1:0] lk_addr_o,
  input  logic [AW:0]   lk_base_i,
  input  logic [AW:0]   lk_lim_i,
  // status decode
  input  logic          st_ready_i,
  input  erase_err_e    st_code_i,
  // memory bus
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [15:0]   bus_wdata_o,
  input  logic [15:0]   bus_rdata_i,
  input  logic          bus_ack_i,
  // result
  output logic          busy_o,
  output logic          done_o,
  output erase_err_e    err_o
);

  localparam logic [AW:0]   DEV_SIZE = {1'b1, {AW{1'b0}}};
  localparam logic [AW-1:0] LOCK_OFF = AW'(LOCK_OFS);

  seq_state_e  state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic          cur_en;
  logic [AW:0]   end_q, end_d;
  logic          end_en;
  logic          single_q;
  logic          single_en;
  erase_err_e    code_q;
  logic          code_en;
  erase_err_e    err_q, err_d;
  logic          err_en;

  logic [AW-1:0] bank_addr;
  logic          lim_stop;

  assign bank_addr = {cur_q[AW-1:BANK_BITS], {BANK_BITS{1'b0}}};
  assign lim_stop  = (lk_lim_i == end_q) || (lk_lim_i == DEV_SIZE);
  assign lk_addr_o = (state_q == ST_CHK_END) ? end_q[AW-1:0] : cur_q;

  // next state and bus drive
  always_comb begin
    state_d     = state_q;
    cur_en      = 1'b0;
    cur_d       = cur_q;
    end_en      = 1'b0;
    end_d       = end_q;
    single_en   = 1'b0;
    code_en     = 1'b0;
    err_en      = 1'b0;
    err_d       = err_q;
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_CHK_START;
          cur_en    = 1'b1;
          cur_d     = start_addr_i;
          end_en    = 1'b1;
          end_d     = end_addr_i;
          single_en = 1'b1;
        end
      end

      ST_CHK_START: begin
        if (lk_base_i != {1'b0, cur_q}) begin
          state_d = ST_FIN;
          err_en  = 1'b1;
          err_d   = ERR_ALIGN;
        end else if (single_q) begin
          end_en  = 1'b1;
          end_d   = lk_lim_i;
          state_d = ST_ID_W;
        end else begin
          state_d = ST_CHK_END;
        end
      end

      ST_CHK_END: begin
        if (end_q > DEV_SIZE) begin
          state_d = ST_FIN;
          err_en  = 1'b1;
          err_d   = ERR_ALIGN;
        end else if (end_q != DEV_SIZE && lk_base_i != end_q) begin
          state_d = ST_FIN;
          err_en  = 1'b1;
          err_d   = ERR_ALIGN;
        end else if (end_q == {1'b0, cur_q}) begin
          state_d = ST_FIN;
          err_en  = 1'b1;
          err_d   = ERR_NONE;
        end else begin
          state_d = ST_ID_W;
        end
      end

      ST_ID_W: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = bank_addr;
        bus_wdata_o = CMD_IDENT;
        if (bus_ack_i) state_d = ST_LOCK_R;
      end

      ST_LOCK_R: begin
        bus_req_o  = 1'b1;
        bus_addr_o = cur_q + LOCK_OFF;
        if (bus_ack_i) state_d = (|bus_rdata_i) ? ST_UNL1_W : ST_ERA1_W;
      end

      ST_UNL1_W: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = cur_q;
        bus_wdata_o = CMD_PROT_SET;
        if (bus_ack_i) state_d = ST_UNL2_W;
      end

      ST_UNL2_W: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = cur_q;
        bus_wdata_o = CMD_UNLOCK;
        if (bus_ack_i) state_d = ST_ERA1_W;
      end

      ST_ERA1_W: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = bank_addr;
        bus_wdata_o = CMD_ERA_SETUP;
        if (bus_ack_i) state_d = ST_ERA2_W;
      end

      ST_ERA2_W: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = cur_q;
        bus_wdata_o = CMD_ERA_CONF;
        if (bus_ack_i) state_d = ST_POLL_R;
      end

      ST_POLL_R: begin
        bus_req_o  = 1'b1;
        bus_addr_o = bank_addr;
        if (bus_ack_i && st_ready_i) begin
          code_en = 1'b1;
          state_d = ST_RDARR_W;
        end
      end

      ST_RDARR_W: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = bank_addr;
        bus_wdata_o = CMD_RD_ARRAY;
        if (bus_ack_i) begin
          if (code_q != ERR_NONE) begin
            state_d = ST_CLR_W;
          end else if (lim_stop) begin
            state_d = ST_FIN;
            err_en  = 1'b1;
            err_d   = ERR_NONE;
          end else begin
            cur_en  = 1'b1;
            cur_d   = lk_lim_i[AW-1:0];
            state_d = ST_ID_W;
          end
        end
      end

      ST_CLR_W: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = bank_addr;
        bus_wdata_o = CMD_CLR_STAT;
        if (bus_ack_i) begin
          state_d = ST_FIN;
          err_en  = 1'b1;
          err_d   = code_q;
        end
      end

      ST_FIN: begin
        state_d = ST_IDLE;
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      end_q    <= '0;
      single_q <= 1'b0;
      code_q   <= ERR_NONE;
      err_q    <= ERR_NONE;
    end else begin
      state_q <= state_d;
      if (cur_en)    cur_q    <= cur_d;
      if (end_en)    end_q    <= end_d;
      if (single_en) single_q <= single_i;
      if (code_en)   code_q   <= st_code_i;
      if (err_en)    err_q    <= err_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
  assign err_o  = err_q;

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_erase_pkg::*;
#(
  parameter int AW         = 12,
  parameter int SMALL_BITS = 8,
  parameter int BIG_BITS   = 10,
  parameter int BOOT_SECTS = 4,
  parameter int BANK_BITS  = 11,
  parameter int LOCK_OFS   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW:0]   end_addr_i,
  input  logic          single_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    err_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [15:0]   bus_wdata_o,
  input  logic [15:0]   bus_rdata_i,
  input  logic          bus_ack_i
);

  logic          rst_n_int;
  logic [AW-1:0] lk_addr;
  logic [AW:0]   lk_base;
  logic [AW:0]   lk_lim;
  stat_bits_t    st_bits;
  logic          st_ready;
  erase_err_e    st_code;
  erase_err_e    err_int;

  nor_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  nor_sector_limits #(
    .AW(AW), .SMALL_BITS(SMALL_BITS), .BIG_BITS(BIG_BITS), .BOOT_SECTS(BOOT_SECTS)
  ) u_geom (
    .addr_i (lk_addr),
    .base_o (lk_base),
    .lim_o  (lk_lim)
  );

  assign st_bits = '{rdy: bus_rdata_i[7], b5: bus_rdata_i[5], b4: bus_rdata_i[4],
                     b3: bus_rdata_i[3], b1: bus_rdata_i[1]};

  nor_status_decode u_dec (
    .st_i    (st_bits),
    .ready_o (st_ready),
    .code_o  (st_code)
  );

  nor_erase_ctrl #(
    .AW(AW), .BANK_BITS(BANK_BITS), .LOCK_OFS(LOCK_OFS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .end_addr_i   (end_addr_i),
    .single_i     (single_i),
    .lk_addr_o    (lk_addr),
    .lk_base_i    (lk_base),
    .lk_lim_i     (lk_lim),
    .st_ready_i   (st_ready),
    .st_code_i    (st_code),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_rdata_i  (bus_rdata_i),
    .bus_ack_i    (bus_ack_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_int)
  );

  assign err_o = err_int;

endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    err_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [15:0]   bus_wdata_o,
  input logic          bus_ack_i
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o);

  // R10
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_o) |-> done_o);

  // R7
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_req_o);

endmodule

bind nor_erase_seq nor_erase_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;
  localparam int DEV        = 4096;
  localparam int NSECT      = 7;
  localparam int POLL_BUSY  = 2;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] start_addr_i;
  logic [AW:0]   end_addr_i;
  logic          single_i;
  logic          busy_o;
  logic          done_o;
  logic [1:0]    err_o;
  logic          bus_req_o;
  logic          bus_we_o;
  logic [AW-1:0] bus_addr_o;
  logic [15:0]   bus_wdata_o;
  logic [15:0]   bus_rdata_i;
  logic          bus_ack_i;

  nor_erase_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .end_addr_i(end_addr_i), .single_i(single_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // flash model state
  int        log_a [0:255];
  int        log_d [0:255];
  int        log_n;
  int        rd_n;
  bit        lock_init [0:NSECT-1];
  bit        lock_m    [0:NSECT-1];
  int        stat_s    [0:NSECT-1];
  int        mode;
  bit        prot_pend;
  bit        era_pend;
  int        poll_cnt;
  int        msec;

  int        exp_a [0:255];
  int        exp_d [0:255];
  int        exp_n;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sbase(int i);
    return (i < 4) ? i * 256 : 1024 + (i - 4) * 1024;
  endfunction

  function automatic int sidx(int a);
    return (a < 1024) ? a / 256 : 4 + (a - 1024) / 1024;
  endfunction

  function automatic int bank(int a);
    return (a >= 2048) ? 2048 : 0;
  endfunction

  // bus responder: one access per acknowledge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack_i <= 1'b0;
    end else if (bus_req_o && !bus_ack_i) begin
      bus_ack_i <= 1'b1;
      if (bus_we_o) begin
        if (log_n < 256) begin
          log_a[log_n] = int'(bus_addr_o);
          log_d[log_n] = int'(bus_wdata_o);
        end
        log_n++;
        case (bus_wdata_o)
          16'h0090: mode = 1;
          16'h0060: prot_pend = 1'b1;
          16'h0020: era_pend = 1'b1;
          16'h00D0: begin
            if (prot_pend) begin
              lock_m[sidx(int'(bus_addr_o))] = 1'b0;
              prot_pend = 1'b0;
            end else if (era_pend) begin
              era_pend = 1'b0;
              mode = 2;
              poll_cnt = 0;
              msec = sidx(int'(bus_addr_o));
            end
          end
          16'h00FF: mode = 0;
          default: ;
        endcase
      end else begin
        rd_n++;
        if (mode == 1) begin
          bus_rdata_i <= {15'd0, lock_m[sidx(int'(bus_addr_o))]};
        end else if (mode == 2) begin
          if (poll_cnt < POLL_BUSY) begin
            bus_rdata_i <= 16'h0000;
            poll_cnt++;
          end else begin
            bus_rdata_i <= 16'(stat_s[msec]);
          end
        end else begin
          bus_rdata_i <= 16'hFFFF;
        end
      end
    end else begin
      bus_ack_i <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d (0x%0h) expected=%0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  task automatic add_exp(input int a, input int d);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  // expected write list for an aligned request; fail_s < 0 means no failure
  task automatic build_exp(input int sa, input int ea, input bit sg, input int fail_s);
    int first;
    int last;
    int e;
    exp_n = 0;
    first = sidx(sa);
    if (sg) last = first + 1;
    else if (ea == DEV) last = NSECT;
    else begin
      e = sidx(ea);
      if (e > first) last = e;
      else if (e == first) last = first;
      else last = NSECT;
    end
    for (int s = first; s < last; s++) begin
      int b;
      b = sbase(s);
      add_exp(bank(b), 16'h0090);
      if (lock_init[s]) begin
        add_exp(b, 16'h0060);
        add_exp(b, 16'h00D0);
      end
      add_exp(bank(b), 16'h0020);
      add_exp(b, 16'h00D0);
      add_exp(bank(b), 16'h00FF);
      if (s == fail_s) begin
        add_exp(bank(b), 16'h0050);
        break;
      end
    end
  endtask

  task automatic run_op(input int sa, input int ea, input bit sg,
                        input logic [1:0] xerr, input string req, input bit cmp_log);
    int cyc;
    int bad;
    log_n = 0;
    rd_n  = 0;
    mode  = 0;
    prot_pend = 1'b0;
    era_pend  = 1'b0;
    for (int s = 0; s < NSECT; s++) lock_m[s] = lock_init[s];
    @(negedge clk);
    start_addr_i = AW'(sa);
    end_addr_i   = (AW+1)'(ea);
    single_i     = sg;
    start_i      = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 6000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o === 1'b1, "R10", "done seen", int'(done_o), 1);
    chk(err_o === xerr, req, "error code", int'(err_o), int'(xerr));
    @(negedge clk);
    chk(!done_o && !busy_o, "R10", "idle after done", int'({busy_o, done_o}), 0);
    if (cmp_log) begin
      bad = 0;
      for (int k = 0; k < exp_n && k < 256; k++)
        if (log_a[k] != exp_a[k] || log_d[k] != exp_d[k]) bad++;
      chk(log_n == exp_n && bad == 0, req, "write count / mismatches",
          log_n * 1000 + bad, exp_n * 1000);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    start_addr_i = '0;
    end_addr_i = '0;
    single_i = 1'b0;
    bus_rdata_i = '0;
    log_n = 0;
    rd_n = 0;
    mode = 0;
    poll_cnt = 0;
    msec = 0;
    prot_pend = 1'b0;
    era_pend = 1'b0;
    for (int s = 0; s < NSECT; s++) begin
      lock_init[s] = 1'b0;
      stat_s[s] = 16'h0080;
    end
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !bus_req_o && err_o == 2'b00, "R10", "reset state",
        int'({busy_o, done_o, bus_req_o, err_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !bus_req_o, "R10", "idle after reset", int'({busy_o, bus_req_o}), 0);

    // R3 R4 R5 R7 R8: sweep every aligned start against every end and single mode
    for (int pass = 0; pass < 2; pass++) begin
      for (int s = 0; s < NSECT; s++) lock_init[s] = ((s + pass) % 2) == 1;
      for (int si = 0; si < NSECT; si++) begin
        for (int ei = 0; ei <= NSECT + 1; ei++) begin
          int ea;
          bit sg;
          sg = (ei == NSECT + 1);
          ea = (ei >= NSECT) ? DEV : sbase(ei);
          if (sg) ea = 7;  // ignored value, not a sector base
          build_exp(sbase(si), ea, sg, -1);
          run_op(sbase(si), ea, sg, 2'b00, sg ? "R3" : "R8", 1'b1);
        end
      end
    end

    // R1: misaligned start
    for (int s = 0; s < NSECT; s++) lock_init[s] = 1'b0;
    exp_n = 0;
    run_op(300, 1024, 1'b0, 2'b01, "R1", 1'b1);
    chk(rd_n == 0, "R1", "no reads", rd_n, 0);
    run_op(1025, 0, 1'b1, 2'b01, "R1", 1'b1);

    // R2: misaligned end and end beyond the device
    exp_n = 0;
    run_op(0, 1500, 1'b0, 2'b01, "R2", 1'b1);
    chk(rd_n == 0, "R2", "no reads", rd_n, 0);
    run_op(1024, 5000, 1'b0, 2'b01, "R2", 1'b1);
    run_op(2048, 300, 1'b0, 2'b01, "R2", 1'b1);

    // R3: empty range
    exp_n = 0;
    run_op(512, 512, 1'b0, 2'b00, "R3", 1'b1);
    chk(rd_n == 0, "R3", "no reads on empty range", rd_n, 0);

    // R6 R7: status precedence, failing sector 1 of range 0..1024
    begin
      int st_v [0:6];
      logic [1:0] st_e [0:6];
      st_v[0] = 16'h0088; st_e[0] = 2'b10;
      st_v[1] = 16'h00B0; st_e[1] = 2'b10;
      st_v[2] = 16'h00A0; st_e[2] = 2'b10;
      st_v[3] = 16'h00A2; st_e[3] = 2'b10;
      st_v[4] = 16'h0082; st_e[4] = 2'b11;
      st_v[5] = 16'h008A; st_e[5] = 2'b10;
      st_v[6] = 16'h0090; st_e[6] = 2'b00;
      lock_init[1] = 1'b1;
      for (int k = 0; k < 7; k++) begin
        stat_s[1] = st_v[k];
        build_exp(0, 1024, 1'b0, (st_e[k] == 2'b00) ? -1 : 1);
        run_op(0, 1024, 1'b0, st_e[k], (st_e[k] == 2'b00) ? "R6" : "R7", 1'b1);
      end
      stat_s[1] = 16'h0080;
      lock_init[1] = 1'b0;
    end

    // R10: error holds through the next run, start while busy ignored
    exp_n = 0;
    run_op(300, 0, 1'b1, 2'b01, "R1", 1'b0);
    build_exp(0, 1024, 1'b0, -1);
    log_n = 0;
    rd_n = 0;
    mode = 0;
    for (int s = 0; s < NSECT; s++) lock_m[s] = lock_init[s];
    @(negedge clk);
    start_addr_i = 12'd0;
    end_addr_i = 13'd1024;
    single_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(busy_o === 1'b1, "R10", "busy mid run", int'(busy_o), 1);
    chk(err_o == 2'b01, "R10", "previous error held", int'(err_o), 1);
    start_addr_i = 12'd300;
    single_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    begin
      int cyc;
      int bad;
      cyc = 0;
      while (!done_o && cyc < 6000) begin
        @(negedge clk);
        cyc++;
      end
      chk(err_o == 2'b00, "R10", "second start ignored, code", int'(err_o), 0);
      bad = 0;
      for (int k = 0; k < exp_n; k++)
        if (log_a[k] != exp_a[k] || log_d[k] != exp_d[k]) bad++;
      chk(log_n == exp_n && bad == 0, "R10", "second start ignored, writes",
          log_n * 1000 + bad, exp_n * 1000);
      @(negedge clk);
      chk(!busy_o, "R10", "idle after ignored start", int'(busy_o), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule